// File: doc/BRIEF.md
# Byte-Loaded Four-Channel DAC Sample Register Bank

This block holds the four sample registers that sit between a waveform engine and four external resistor-ladder converters. Each register is 16 bits wide and drives its ladder through a bus carrying the bit-inverted register value. In generated mode every register takes the engine's current sample on each clock, so the ladders follow the engine.

When the direct-mode input is high, the engine's samples are no longer loaded and the registers keep their contents. A host then writes known codes one byte at a time. It picks a channel with a 2-bit select, picks the low or high byte with a byte select, places the byte on the data input and raises the load strobe. The strobe pin has another meaning (freeze) in generated mode. In direct mode it is synchronized and edge-detected, so one rising edge makes exactly one write. The bidirectional pin outputs and their enables are held at zero, so those pins serve only as inputs.

Top module: `dac_byte_bank`

## Requirements
- R1: With `direct_mode` low, every channel register loads its slice of `gen_samples` on each rising clock edge. Channel k uses bits [16k+15:16k] of both `gen_samples` and `ladder_bus_n`.
- R2: With `direct_mode` high, generated samples are not loaded, and a register without a direct write keeps its value whatever `gen_samples` does.
- R3: In direct mode, `chan_sel` values 0, 1, 2 and 3 address channels 0, 1, 2 and 3. A write changes only the addressed channel.
- R4: `byte_hi` = 0 writes `wr_data` into register bits 7:0, and `byte_hi` = 1 writes it into bits 15:8. The other byte of that register is unchanged.
- R5: `load_strobe` passes through a two-flop synchronizer and a rising-edge detector. One rising edge causes exactly one write. Holding the strobe high writes nothing more, even if `wr_data` changes. The write shows on the bus after the third rising clock edge that follows the strobe's rise.
- R6: Each `ladder_bus_n` slice is the bitwise inverse of its register.
- R7: `bidir_out` and `bidir_oe` are always all zeros.
- R8: An active-low `rst_n` clears every register, so every ladder bus reads all ones.
- R9: Strobe edges while `direct_mode` is low cause no direct write; the registers keep following `gen_samples`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_mode | input | 1 | 1 = host byte writes, 0 = follow engine samples |
| chan_sel | input | 2 | Channel addressed by a direct write |
| byte_hi | input | 1 | 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Byte value to load |
| load_strobe | input | 1 | Write strobe in direct mode (asynchronous, edge-detected) |
| gen_samples | input | 64 | Four engine samples, channel k at bits [16k+15:16k] |
| ladder_bus_n | output | 64 | Four inverted register buses, channel k at bits [16k+15:16k] |
| bidir_out | output | 8 | Bidirectional pin outputs, fixed zero |
| bidir_oe | output | 8 | Bidirectional pin enables, fixed zero |

## Verification
A generated sample is due one clock edge after it is applied. A direct byte write is due after the third rising edge that follows the strobe's rise: two synchronizer stages, then the register. The bench changes inputs on falling edges and reads the buses on a later falling edge. For writes it waits exactly three rising edges before comparing. It then keeps the strobe high while it changes the data, to show that no second write happens. A reference array of four registers, updated by arithmetic on each stimulus, supplies every expected bus value.

// File: rtl/dac_byte_bank_pkg.sv
package dac_byte_bank_pkg;
  localparam int unsigned NUM_CH_DEF = 4;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned PIN_W_DEF  = 8;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/dac_strobe_edge.sv
module dac_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q, last_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], strobe_async};
    last_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_pulse = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg
  import dac_byte_bank_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned IDX    = 0,
  localparam int unsigned SAMPLE_W = 2 * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                direct_mode,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    chan_sel,
  input  logic                byte_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [SAMPLE_W-1:0] gen_sample,
  output logic [SAMPLE_W-1:0] bus_n
);
  logic [SAMPLE_W-1:0] code_q, code_d;
  logic                hit;
  logic                load_en;

  assign hit     = wr_en && (chan_sel == SEL_W'(IDX));
  assign load_en = !direct_mode || hit;

  always_comb begin
    code_d = code_q;
    if (!direct_mode) begin
      code_d = gen_sample;
    end else if (hit) begin
      if (half_e'(byte_hi) == HALF_HI) begin
        code_d[SAMPLE_W-1:BYTE_W] = wr_data;
      end else begin
        code_d[BYTE_W-1:0] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load_en) begin
      code_q <= code_d;
    end
  end

  assign bus_n = ~code_q;
endmodule

// File: rtl/dac_byte_bank.sv
module dac_byte_bank
  import dac_byte_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  parameter int unsigned PIN_W  = PIN_W_DEF,
  localparam int unsigned SAMPLE_W = 2 * BYTE_W,
  localparam int unsigned SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned BANK_W   = NUM_CH * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              direct_mode,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load_strobe,
  input  logic [BANK_W-1:0] gen_samples,
  output logic [BANK_W-1:0] ladder_bus_n,
  output logic [PIN_W-1:0]  bidir_out,
  output logic [PIN_W-1:0]  bidir_oe
);
  logic strobe_rise;
  logic wr_en;

  dac_strobe_edge #(.SYNC_STAGES(2)) u_edge (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_async (load_strobe),
    .rise_pulse   (strobe_rise)
  );

  assign wr_en = strobe_rise & direct_mode;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan_reg #(
      .BYTE_W (BYTE_W),
      .SEL_W  (SEL_W),
      .IDX    (g)
    ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .direct_mode (direct_mode),
      .wr_en       (wr_en),
      .chan_sel    (chan_sel),
      .byte_hi     (byte_hi),
      .wr_data     (wr_data),
      .gen_sample  (gen_samples[g*SAMPLE_W +: SAMPLE_W]),
      .bus_n       (ladder_bus_n[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  assign bidir_out = '0;
  assign bidir_oe  = '0;
endmodule

// File: rtl/dac_byte_bank_chk.sv
module dac_byte_bank_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PIN_W  = 8,
  localparam int unsigned SAMPLE_W = 2 * BYTE_W,
  localparam int unsigned BANK_W   = NUM_CH * SAMPLE_W,
  localparam int unsigned HALF_W   = NUM_CH * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              direct_mode,
  input logic              byte_hi,
  input logic              wr_en,
  input logic [BANK_W-1:0] gen_samples,
  input logic [BANK_W-1:0] ladder_bus_n,
  input logic [PIN_W-1:0]  bidir_out,
  input logic [PIN_W-1:0]  bidir_oe
);
  logic [HALF_W-1:0] hi_all, lo_all;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_split
    assign hi_all[k*BYTE_W +: BYTE_W] = ladder_bus_n[k*SAMPLE_W + BYTE_W +: BYTE_W];
    assign lo_all[k*BYTE_W +: BYTE_W] = ladder_bus_n[k*SAMPLE_W +: BYTE_W];
  end

  a_r1_follow_gen: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode |=> (ladder_bus_n == ~$past(gen_samples)));

  a_r2_hold_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && !wr_en) |=> $stable(ladder_bus_n));

  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && wr_en && !byte_hi) |=> $stable(hi_all));

  a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && wr_en && byte_hi) |=> $stable(lo_all));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r7_pins_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bidir_out == '0) && (bidir_oe == '0));

  a_r8_reset_ones: assert property (@(posedge clk)
    !rst_n |-> (ladder_bus_n == {BANK_W{1'b1}}));
endmodule

bind dac_byte_bank dac_byte_bank_chk #(
  .NUM_CH (NUM_CH),
  .BYTE_W (BYTE_W),
  .PIN_W  (PIN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .direct_mode  (direct_mode),
  .byte_hi      (byte_hi),
  .wr_en        (wr_en),
  .gen_samples  (gen_samples),
  .ladder_bus_n (ladder_bus_n),
  .bidir_out    (bidir_out),
  .bidir_oe     (bidir_oe)
);

// File: tb/dac_byte_bank_tb.sv
module dac_byte_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        direct_mode = 1'b0;
  logic [1:0]  chan_sel = '0;
  logic        byte_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        load_strobe = 1'b0;
  logic [63:0] gen_samples = '0;
  logic [63:0] ladder_bus_n;
  logic [7:0]  bidir_out, bidir_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [4];

  always #10 clk = ~clk;

  dac_byte_bank u_dut (
    .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .chan_sel(chan_sel),
    .byte_hi(byte_hi), .wr_data(wr_data), .load_strobe(load_strobe),
    .gen_samples(gen_samples), .ladder_bus_n(ladder_bus_n),
    .bidir_out(bidir_out), .bidir_oe(bidir_oe)
  );

  function automatic logic [63:0] expect_bus();
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[k*16 +: 16] = ~model[k];
    return v;
  endfunction

  task automatic check_bus(input string req);
    n_cmp++;
    if (ladder_bus_n !== expect_bus()) begin
      n_bad++;
      $display("FAIL %s: ladder_bus_n=%h expected=%h", req, ladder_bus_n, expect_bus());
    end
  endtask

  task automatic check_pins(input string req);
    n_cmp++;
    if (bidir_out !== 8'h00 || bidir_oe !== 8'h00) begin
      n_bad++;
      $display("FAIL %s: out=%h oe=%h expected=00 00", req, bidir_out, bidir_oe);
    end
  endtask

  // R1: generated sample visible one edge after it is applied
  task automatic gen_step(input logic [63:0] s, input string req);
    @(negedge clk);
    gen_samples = s;
    @(posedge clk);
    for (int k = 0; k < 4; k++) model[k] = s[k*16 +: 16];
    @(negedge clk);
    check_bus(req);
  endtask

  // R3 R4 R5: one strobe rise, due after third rising edge
  task automatic dwrite(input int ch, input logic hi, input logic [7:0] d);
    @(negedge clk);
    chan_sel = 2'(ch);
    byte_hi = hi;
    wr_data = d;
    load_strobe = 1'b1;
    repeat (3) @(posedge clk);
    if (hi) model[ch][15:8] = d; else model[ch][7:0] = d;
    @(negedge clk);
    check_bus("R3/R4 direct byte write");
    wr_data = ~d;
    repeat (3) @(negedge clk);
    check_bus("R5 held strobe writes once");
    load_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    check_bus("R8 reset buses all ones");
    check_pins("R7 pins zero in reset");
    rst_n = 1'b1;

    // R1 generated patterns
    gen_step(64'h0123_4567_89AB_CDEF, "R1 gen pattern a");
    gen_step(64'hFFFF_0000_A5A5_5A5A, "R1 gen pattern b");
    for (int i = 0; i < 16; i++)
      gen_step({16'(i * 7919), 16'(i * 31), 16'(1 << i), 16'(~(1 << i))}, "R1 R6 gen sweep");

    // R9 strobe toggles in generated mode
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      load_strobe = 1'b1; chan_sel = 2'(i); wr_data = 8'h3C;
      gen_step(64'h1111_2222_3333_4444 + 64'(i), "R9 strobe ignored in gen mode");
      repeat (3) @(negedge clk);
      load_strobe = 1'b0;
      gen_step(64'h9999_8888_7777_6666 + 64'(i), "R9 gen tracks after strobe");
    end

    // R2 switch to direct: registers hold last generated values
    @(negedge clk);
    direct_mode = 1'b1;
    gen_samples = 64'hDEAD_BEEF_CAFE_F00D;
    repeat (4) @(negedge clk);
    check_bus("R2 gen ignored in direct mode");

    // R3 R4 near-exhaustive channel/half sweep
    for (int ch = 0; ch < 4; ch++)
      for (int h = 0; h < 2; h++)
        for (int p = 0; p < 4; p++)
          dwrite(ch, h[0], 8'((ch * 64) + (h * 32) + (p * 9) + 1));

    @(negedge clk);
    gen_samples = 64'h0F0F_F0F0_1234_4321;
    repeat (5) @(negedge clk);
    check_bus("R2 hold after writes");
    check_pins("R7 pins zero in direct mode");

    // back to generated mode
    @(negedge clk);
    direct_mode = 1'b0;
    gen_step(64'h2468_ACE0_1357_9BDF, "R1 resume generated");

    // R8 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) model[k] = '0;
    @(negedge clk);
    check_bus("R8 reset clears registers");
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule